// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the per-vector message table and the pending bits of a message-signalled interrupt function with up to 32 vectors, all inside one 4 KiB register window. A device raises an interrupt by presenting a vector number. If the vector is in use and its masks allow delivery, the block emits one message: a 32-bit data word aimed at a 64-bit address, both taken from that vector's table entry. Otherwise the request is kept as a pending bit.

Pending bits drain without software help. When software clears a vector's own mask, clears the function-wide mask, or sets the enable bit, every pending vector that is now deliverable is sent. Vectors go out one per output handshake, lowest number first. Device logic declares which vectors it uses through per-vector use counters. A vector whose count is zero ignores requests, and its pending bit is cleared when its count falls to zero.

Top module: `msix_vector_ctrl`

## Requirements
- R1: Window accesses are 32 bits wide and `reg_addr[1:0]` is ignored. Entry v occupies the 16 bytes at offset v*16. From the lowest address up, the words are: address bits 31:0, address bits 63:32, message data, and control. Control bit 0 is the vector mask; the other control bits always read as zero.
- R2: After reset, enable and mask-all read 0 and every address and data word is 0. Every entry's control word reads 1 (masked). The pending word reads 0, all use counts are 0, and `msg_valid` is 0.
- R3: The pending word is at offset 0x800, and bit v of it is vector v. Writes to it are ignored. Every other location outside the table reads as zero, and writes to those locations are ignored.
- R4: A request is dropped if its vector is at or above NUM_VEC or its use count is zero. A dropped request sets no pending bit and sends no message.
- R5: A request for a vector that is masked by its own mask bit, by mask-all, or because enable is clear sets that vector's pending bit and sends no message.
- R6: A request for an enabled, unmasked vector in use raises `msg_valid` on the second rising edge after the request is sampled. `msg_addr` is {high word, low word} of the entry and `msg_data` is its data word.
- R7: A table write that clears a pending vector's mask bit sends that vector's message and clears its pending bit.
- R8: The control port `ctl_wdata` has bit 0 = enable and bit 1 = mask-all. A control write that leaves enable clear sends nothing. A write that sets enable with mask-all clear sends every deliverable pending vector.
- R9: When several vectors are deliverable at once, their messages are emitted one per accepted handshake in ascending vector order.
- R10: While `msg_valid` is high and `msg_ready` is low, address and data hold steady. Requests that arrive meanwhile show as pending bits until they are sent.
- R11: The use port (`use_up` = 1 for use, 0 for unuse) changes a saturating per-vector count. When the count reaches zero the vector's pending bit is cleared. An unuse at zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Window write strobe |
| reg_addr | input | 12 | Byte offset within the window |
| reg_wdata | input | 32 | Window write data |
| reg_rdata | output | 32 | Window read data, combinational from `reg_addr` |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 2 | Bit 0 enable, bit 1 mask-all |
| ctl_enable | output | 1 | Current enable bit |
| ctl_maskall | output | 1 | Current mask-all bit |
| use_valid | input | 1 | Use-count update strobe |
| use_up | input | 1 | 1 = use, 0 = unuse |
| use_vec | input | 5 | Vector for the use-count update |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 5 | Requested vector |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted by downstream |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
The hardest situation to reach from the ports is a burst of several pending vectors draining in order after a single unmask. Vectors have to be made pending under mask-all with enable set, then tested against a write that leaves enable clear, and only then released. The bench sets this up in stages and holds `msg_ready` low between pops, so each message in the ordered burst is inspected by itself. A second stall scenario issues a new request while the output is blocked. It then reads the pending word to see that request held, before the pop lets it through.

// File: rtl/msix_pkg.sv
package msix_pkg;
    localparam int WIN_AW     = 12;
    localparam int MAX_VEC    = 32;
    localparam int VEC_W      = 5;
    localparam logic [WIN_AW-3:0] PEND_DWORD = 10'h200;  // byte offset 0x800

    typedef enum logic [1:0] {
        W_ADDR_LO = 2'd0,
        W_ADDR_HI = 2'd1,
        W_DATA    = 2'd2,
        W_CTRL    = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic        masked;
    } entry_t;

    localparam entry_t ENTRY_RESET = '{addr_lo: 32'h0, addr_hi: 32'h0,
                                       data: 32'h0, masked: 1'b1};
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  word_sel_e          wr_sel,
    input  logic [31:0]        wr_data,
    input  logic [IW-1:0]      rd_idx,
    input  word_sel_e          rd_sel,
    output logic [31:0]        rd_data,
    input  logic [IW-1:0]      msg_idx,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [NUM_VEC-1:0] vec_mask
);
    entry_t ent_q [NUM_VEC];
    entry_t ent_d [NUM_VEC];

    always_comb begin
        ent_d = ent_q;
        if (wr_en) begin
            case (wr_sel)
                W_ADDR_LO: ent_d[wr_idx].addr_lo = wr_data;
                W_ADDR_HI: ent_d[wr_idx].addr_hi = wr_data;
                W_DATA:    ent_d[wr_idx].data    = wr_data;
                default:   ent_d[wr_idx].masked  = wr_data[0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VEC; i++) ent_q[i] <= ENTRY_RESET;
        end else begin
            ent_q <= ent_d;
        end
    end

    always_comb begin
        case (rd_sel)
            W_ADDR_LO: rd_data = ent_q[rd_idx].addr_lo;
            W_ADDR_HI: rd_data = ent_q[rd_idx].addr_hi;
            W_DATA:    rd_data = ent_q[rd_idx].data;
            default:   rd_data = {31'h0, ent_q[rd_idx].masked};
        endcase
    end

    assign msg_addr = {ent_q[msg_idx].addr_hi, ent_q[msg_idx].addr_lo};
    assign msg_data = ent_q[msg_idx].data;

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_mask
        assign vec_mask[g] = ent_q[g].masked;
    end
endmodule

// File: rtl/msix_use_ctr.sv
module msix_use_ctr #(
    parameter int NUM_VEC = 8,
    parameter int CNT_W   = 4,
    localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_valid,
    input  logic               upd_up,
    input  logic [IW-1:0]      upd_idx,
    output logic [NUM_VEC-1:0] in_use,
    output logic [NUM_VEC-1:0] hit_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q [NUM_VEC];
    logic [CNT_W-1:0] cnt_d [NUM_VEC];

    always_comb begin
        cnt_d    = cnt_q;
        hit_zero = '0;
        if (upd_valid) begin
            if (upd_up) begin
                if (cnt_q[upd_idx] != CNT_MAX) cnt_d[upd_idx] = cnt_q[upd_idx] + CNT_ONE;
            end else if (cnt_q[upd_idx] != '0) begin
                cnt_d[upd_idx] = cnt_q[upd_idx] - CNT_ONE;
                if (cnt_q[upd_idx] == CNT_ONE) hit_zero[upd_idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VEC; i++) cnt_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_use
        assign in_use[g] = (cnt_q[g] != '0);
    end
endmodule

// File: rtl/msix_first_set.sv
module msix_first_set #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/msix_vector_ctrl.sv
module msix_vector_ctrl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [WIN_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ctl_we,
    input  logic [1:0]        ctl_wdata,
    output logic              ctl_enable,
    output logic              ctl_maskall,
    input  logic              use_valid,
    input  logic              use_up,
    input  logic [VEC_W-1:0]  use_vec,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vec,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data
);
    localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
    localparam logic [VEC_W:0] VEC_LIMIT = (VEC_W + 1)'(NUM_VEC);
    localparam logic [WIN_AW-5:0] ENT_LIMIT = (WIN_AW - 4)'(NUM_VEC);

    typedef struct packed {
        logic               en;
        logic               maskall;
        logic [NUM_VEC-1:0] pend;
        logic               mv;
        logic [IW-1:0]      mvec;
        logic [63:0]        maddr;
        logic [31:0]        mdata;
    } state_t;

    state_t st_q, st_d;

    // window decode
    logic        tbl_hit, pend_hit, tbl_wr;
    logic [31:0] tbl_rd;
    logic        unused_addr_bits;
    assign unused_addr_bits = ^reg_addr[1:0];
    assign tbl_hit  = (reg_addr[WIN_AW-1:4] < ENT_LIMIT);
    assign pend_hit = (reg_addr[WIN_AW-1:2] == PEND_DWORD);
    assign tbl_wr   = reg_we && tbl_hit;

    // vector table
    logic [NUM_VEC-1:0] vec_mask;
    logic [IW-1:0]      pick_idx;
    logic               pick_found;
    logic [63:0]        sel_addr;
    logic [31:0]        sel_data;

    msix_vec_table #(.NUM_VEC(NUM_VEC)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_idx   (reg_addr[4+IW-1:4]),
        .wr_sel   (word_sel_e'(reg_addr[3:2])),
        .wr_data  (reg_wdata),
        .rd_idx   (reg_addr[4+IW-1:4]),
        .rd_sel   (word_sel_e'(reg_addr[3:2])),
        .rd_data  (tbl_rd),
        .msg_idx  (pick_idx),
        .msg_addr (sel_addr),
        .msg_data (sel_data),
        .vec_mask (vec_mask)
    );

    // use counters
    logic [NUM_VEC-1:0] in_use, hit_zero;
    logic               use_ok;
    assign use_ok = use_valid && ({1'b0, use_vec} < VEC_LIMIT);

    msix_use_ctr #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) i_use (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (use_ok),
        .upd_up    (use_up),
        .upd_idx   (use_vec[IW-1:0]),
        .in_use    (in_use),
        .hit_zero  (hit_zero)
    );

    // delivery arbitration
    logic [NUM_VEC-1:0] eligible;
    assign eligible = st_q.pend & ~vec_mask & {NUM_VEC{st_q.en & ~st_q.maskall}};

    msix_first_set #(.N(NUM_VEC)) i_pick (
        .req   (eligible),
        .found (pick_found),
        .idx   (pick_idx)
    );

    logic req_ok, slot_free;
    assign req_ok    = req_valid && ({1'b0, req_vec} < VEC_LIMIT) && in_use[req_vec[IW-1:0]];
    assign slot_free = !st_q.mv || msg_ready;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.en      = ctl_wdata[0];
            st_d.maskall = ctl_wdata[1];
        end
        if (st_q.mv && msg_ready) st_d.mv = 1'b0;
        if (slot_free && pick_found) begin
            st_d.mv             = 1'b1;
            st_d.mvec           = pick_idx;
            st_d.maddr          = sel_addr;
            st_d.mdata          = sel_data;
            st_d.pend[pick_idx] = 1'b0;
        end
        if (req_ok) st_d.pend[req_vec[IW-1:0]] = 1'b1;
        st_d.pend = st_d.pend & ~hit_zero;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (tbl_hit)       reg_rdata = tbl_rd;
        else if (pend_hit) reg_rdata = 32'(st_q.pend);
        else               reg_rdata = 32'h0;
    end

    assign ctl_enable  = st_q.en;
    assign ctl_maskall = st_q.maskall;
    assign msg_valid   = st_q.mv;
    assign msg_addr    = st_q.maddr;
    assign msg_data    = st_q.mdata;
endmodule

// File: rtl/msix_vt_checker.sv
module msix_vt_checker #(
    parameter int NUM_VEC = 8,
    localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic               ctl_enable,
    input logic               ctl_maskall,
    input logic               req_valid,
    input logic [NUM_VEC-1:0] vec_mask,
    input logic [NUM_VEC-1:0] pend,
    input logic [IW-1:0]      msg_vec
);
    logic [NUM_VEC-1:0] mask_prev;
    always_ff @(posedge clk) mask_prev <= vec_mask;

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    a_r5_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(ctl_enable));

    a_r5_maskall_gates: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !$past(ctl_maskall));

    a_r5_vecmask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !mask_prev[msg_vec]);

    a_r4_pend_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        |(pend & ~$past(pend)) |-> $past(req_valid));
endmodule

bind msix_vector_ctrl msix_vt_checker #(.NUM_VEC(NUM_VEC)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_addr    (msg_addr),
    .msg_data    (msg_data),
    .ctl_enable  (ctl_enable),
    .ctl_maskall (ctl_maskall),
    .req_valid   (req_valid),
    .vec_mask    (vec_mask),
    .pend        (st_q.pend),
    .msg_vec     (st_q.mvec)
);

// File: tb/test_msix_vector_ctrl.sv
`timescale 1ns/1ps
module test_msix_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_wdata = '0;
    logic        ctl_enable, ctl_maskall;
    logic        use_valid = 1'b0, use_up = 1'b0;
    logic [4:0]  use_vec = '0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_vec = '0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    msix_vector_ctrl #(.NUM_VEC(8), .CNT_W(4)) i_msix_vector_ctrl (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic ctl_wr(logic [1:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic use_op(int v, bit up);
        @(negedge clk); use_valid = 1'b1; use_up = up; use_vec = 5'(v);
        @(negedge clk); use_valid = 1'b0;
    endtask

    task automatic req(int v);
        @(negedge clk); req_valid = 1'b1; req_vec = 5'(v);
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); msg_ready = 1'b1;
        @(negedge clk); msg_ready = 1'b0;
    endtask

    task automatic prog(int v, logic [63:0] a, logic [31:0] d, bit m);
        reg_wr(12'(v * 16),      a[31:0]);
        reg_wr(12'(v * 16 + 4),  a[63:32]);
        reg_wr(12'(v * 16 + 8),  d);
        reg_wr(12'(v * 16 + 12), {31'h0, m});
    endtask

    function automatic logic [63:0] va(int v);
        return {32'h0000_00A0 + 32'(v), 32'h1000_0000 + 32'(v * 16)};
    endfunction
    function automatic logic [31:0] vd(int v);
        return 32'hD000_0000 + 32'(v);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R2 enable", 64'(ctl_enable), 64'd0);
        chk("R2 maskall", 64'(ctl_maskall), 64'd0);
        chk("R2 msg_valid", 64'(msg_valid), 64'd0);
        reg_rd(12'h00C, d); chk("R2 ctrl vec0", 64'(d), 64'd1);
        reg_rd(12'h07C, d); chk("R2 ctrl vec7", 64'(d), 64'd1);
        reg_rd(12'h030, d); chk("R2 addr vec3", 64'(d), 64'd0);
        reg_rd(12'h800, d); chk("R2 pending", 64'(d), 64'd0);
    endtask

    task automatic t_align();
        logic [31:0] d;
        reg_wr(12'h013, 32'hCAFE_0001);
        reg_rd(12'h010, d); chk("R1 aligned write", 64'(d), 64'hCAFE_0001);
        reg_rd(12'h012, d); chk("R1 aligned read", 64'(d), 64'hCAFE_0001);
        reg_wr(12'h01C, 32'hFFFF_FFFE);
        reg_rd(12'h01C, d); chk("R1 ctrl upper bits", 64'(d), 64'd0);
        reg_wr(12'h01C, 32'h1);
        reg_rd(12'h01C, d); chk("R1 ctrl mask bit", 64'(d), 64'd1);
    endtask

    task automatic t_window();
        logic [31:0] d;
        reg_wr(12'h800, 32'hFFFF_FFFF);
        reg_rd(12'h800, d); chk("R3 pending write ignored", 64'(d), 64'd0);
        reg_rd(12'h400, d); chk("R3 gap reads zero", 64'(d), 64'd0);
        reg_wr(12'h080, 32'h1234_5678);
        reg_rd(12'h080, d); chk("R3 beyond table", 64'(d), 64'd0);
    endtask

    task automatic t_drop();
        logic [31:0] d;
        ctl_wr(2'b01);
        prog(2, va(2), vd(2), 1'b0);
        req(2);
        @(negedge clk);
        chk("R4 unused vector no msg", 64'(msg_valid), 64'd0);
        reg_rd(12'h800, d); chk("R4 unused vector no pend", 64'(d), 64'd0);
        use_op(9, 1'b1);
        req(9);
        @(negedge clk);
        chk("R4 out of range no msg", 64'(msg_valid), 64'd0);
        reg_rd(12'h800, d); chk("R4 out of range no pend", 64'(d), 64'd0);
    endtask

    task automatic t_masked();
        logic [31:0] d;
        use_op(2, 1'b1);
        reg_wr(12'h02C, 32'h1);
        req(2);
        @(negedge clk);
        chk("R5 own mask no msg", 64'(msg_valid), 64'd0);
        reg_rd(12'h800, d); chk("R5 own mask pend", 64'(d), 64'h04);
        ctl_wr(2'b11);
        reg_wr(12'h02C, 32'h0);
        @(negedge clk);
        chk("R5 maskall no msg", 64'(msg_valid), 64'd0);
        use_op(5, 1'b1);
        prog(5, va(5), vd(5), 1'b0);
        req(5);
        @(negedge clk);
        reg_rd(12'h800, d); chk("R5 maskall pend", 64'(d), 64'h24);
    endtask

    task automatic t_ctl_replay();
        logic [31:0] d;
        ctl_wr(2'b00);
        @(negedge clk); @(negedge clk);
        chk("R8 disabled write no msg", 64'(msg_valid), 64'd0);
        reg_rd(12'h800, d); chk("R8 disabled keeps pend", 64'(d), 64'h24);
        ctl_wr(2'b01);
        @(negedge clk);
        chk("R8 replay valid", 64'(msg_valid), 64'd1);
        chk("R9 first is vec2 addr", msg_addr, va(2));
        chk("R9 first is vec2 data", 64'(msg_data), 64'(vd(2)));
        pop();
        chk("R9 second valid", 64'(msg_valid), 64'd1);
        chk("R9 second is vec5", 64'(msg_data), 64'(vd(5)));
        pop();
        chk("R8 drained", 64'(msg_valid), 64'd0);
        reg_rd(12'h800, d); chk("R8 pend cleared", 64'(d), 64'd0);
    endtask

    task automatic t_send();
        req(5);
        @(negedge clk);
        chk("R6 valid", 64'(msg_valid), 64'd1);
        chk("R6 addr", msg_addr, va(5));
        chk("R6 data", 64'(msg_data), 64'(vd(5)));
        pop();
        chk("R6 one message", 64'(msg_valid), 64'd0);
    endtask

    task automatic t_stall();
        logic [31:0] d;
        req(2);
        req(5);
        @(negedge clk); @(negedge clk);
        chk("R10 held valid", 64'(msg_valid), 64'd1);
        chk("R10 held addr", msg_addr, va(2));
        chk("R10 held data", 64'(msg_data), 64'(vd(2)));
        reg_rd(12'h800, d); chk("R10 stalled request pend", 64'(d), 64'h20);
        pop();
        chk("R10 next after pop", 64'(msg_data), 64'(vd(5)));
        pop();
        chk("R10 drained", 64'(msg_valid), 64'd0);
    endtask

    task automatic t_unmask_replay();
        logic [31:0] d;
        reg_wr(12'h05C, 32'h1);
        req(5);
        @(negedge clk);
        chk("R7 masked no msg", 64'(msg_valid), 64'd0);
        reg_wr(12'h05C, 32'h0);
        @(negedge clk);
        chk("R7 replay valid", 64'(msg_valid), 64'd1);
        chk("R7 replay data", 64'(msg_data), 64'(vd(5)));
        reg_rd(12'h800, d); chk("R7 pend cleared", 64'(d), 64'd0);
        pop();
    endtask

    task automatic t_usage();
        logic [31:0] d;
        use_op(3, 1'b1); use_op(3, 1'b1);
        prog(3, va(3), vd(3), 1'b1);
        req(3);
        reg_rd(12'h800, d); chk("R11 pend set", 64'(d), 64'h08);
        use_op(3, 1'b0);
        reg_rd(12'h800, d); chk("R11 count one keeps pend", 64'(d), 64'h08);
        use_op(3, 1'b0);
        reg_rd(12'h800, d); chk("R11 zero clears pend", 64'(d), 64'h00);
        use_op(3, 1'b0);
        use_op(3, 1'b1);
        req(3);
        reg_rd(12'h800, d); chk("R11 unuse at zero no effect", 64'(d), 64'h08);
        use_op(3, 1'b0);
        reg_rd(12'h800, d); chk("R11 cleared again", 64'(d), 64'h00);
        chk("R11 no msg while masked", 64'(msg_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_align();
        t_window();
        t_drop();
        t_masked();
        t_ctl_replay();
        t_send();
        t_stall();
        t_unmask_replay();
        t_usage();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule